// File: doc/BRIEF.md
# State Metric Range Compressor

At each sliding-window boundary of a max-log-MAP turbo decoder, the backward recursion leaves one set of state metrics. These metrics seed the same window in the next iteration. This block shrinks such a set into a short seed word. The word holds the spread between the strongest and the weakest state, clipped to a narrow unsigned field, and the positions of those two states. A recovery stage elsewhere rebuilds starting metrics from the spread and the two positions. The bits stored per boundary then grow with the logarithm of the state count, not with the state count itself.

All metrics arrive in parallel under a valid strobe, as signed two's-complement words. One comparator tree finds the extremes. Its first level holds paired cells that each produce a larger and a smaller value. Above that level, the larger values climb a maximum-only tree and the smaller values climb a minimum-only tree. For eight states this takes ten comparisons in total. The winning indexes are carried along with the compare decisions the tree already makes, so no extra comparator is used. A subtractor with a clip stage forms the spread. With the default build, the result is registered one clock after the strobe.

Top module: `metric_range_compressor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` is 0 after that edge, and `out_range`, `out_max_idx` and `out_min_idx` are 0.
- R2: `out_valid` is 1 in exactly the cycle that follows a rising edge at which `in_valid` was 1, and 0 otherwise.
- R3: When the signed difference between the largest and smallest metric is at most 2^RANGE_W-1 (255 by default), `out_range` equals that difference.
- R4: When that difference exceeds 2^RANGE_W-1, `out_range` equals exactly 2^RANGE_W-1 (255).
- R5: `out_max_idx` is the state number of the largest metric; among equal largest metrics, the lowest state number wins.
- R6: `out_min_idx` is the state number of the smallest metric; among equal smallest metrics, the lowest state number wins.
- R7: In cycles without `in_valid`, `out_range`, `out_max_idx` and `out_min_idx` keep the values of the last captured set.
- R8: When all metrics are equal, `out_range` is 0 and both indexes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Metric set on `in_metrics` is present |
| in_metrics | input | NUM_STATES x METRIC_W (8x12) | Signed metrics; state s occupies element s of the packed array |
| out_valid | output | 1 | Compressed word is new this cycle |
| out_range | output | RANGE_W (8) | Clipped spread between the largest and smallest metric |
| out_max_idx | output | log2(NUM_STATES) (3) | State number of the largest metric |
| out_min_idx | output | log2(NUM_STATES) (3) | State number of the smallest metric |

## Verification
The bench builds the block with its defaults: eight 12-bit states, an 8-bit range field and the registered output. These settings make the full signed span of the metric reachable. A difference of 4095 covers the clip path far beyond the field, and differences of exactly 255 and 256 sit on either side of the clip threshold. Ties between states that sit in different subtrees test the lower-index rule at each level of the tree.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  // Strobes sent from the control half to the datapath half.
  typedef struct packed {
    logic capture;   // latch the compressed word this edge
    logic clear;     // zero the held word (reset)
  } mrc_strobe_t;

  // Offset of the first node of a given tree level in the flat node array.
  function automatic int levelBase(input int numStates, input int lvl);
    return numStates - (numStates >> lvl);
  endfunction

endpackage

// File: rtl/mrc_maxmin_cell.sv
// First-level cell: one compare unit, two selectors. Operand a carries the
// lower state number, so it wins every tie for both outputs.
module mrc_maxmin_cell #(
  parameter int W  = 12,
  parameter int IW = 3
) (
  input  logic [W-1:0]  aVal,
  input  logic [IW-1:0] aIdx,
  input  logic [W-1:0]  bVal,
  input  logic [IW-1:0] bIdx,
  output logic [W-1:0]  hiVal,
  output logic [IW-1:0] hiIdx,
  output logic [W-1:0]  loVal,
  output logic [IW-1:0] loIdx
);
  logic bAbove;
  logic bBelow;

  always_comb begin
    bAbove = $signed(bVal) > $signed(aVal);
    bBelow = $signed(bVal) < $signed(aVal);
    hiVal  = bAbove ? bVal : aVal;
    hiIdx  = bAbove ? bIdx : aIdx;
    loVal  = bBelow ? bVal : aVal;
    loIdx  = bBelow ? bIdx : aIdx;
  end
endmodule

// File: rtl/mrc_pick_cell.sv
// Upper-level cell: one compare, one selector. PICK_MAX chooses the variant.
module mrc_pick_cell #(
  parameter int W        = 12,
  parameter int IW       = 3,
  parameter bit PICK_MAX = 1'b1
) (
  input  logic [W-1:0]  aVal,
  input  logic [IW-1:0] aIdx,
  input  logic [W-1:0]  bVal,
  input  logic [IW-1:0] bIdx,
  output logic [W-1:0]  selVal,
  output logic [IW-1:0] selIdx
);
  logic takeB;

  generate
    if (PICK_MAX) begin : g_max
      assign takeB = $signed(bVal) > $signed(aVal);
    end else begin : g_min
      assign takeB = $signed(bVal) < $signed(aVal);
    end
  endgenerate

  assign selVal = takeB ? bVal : aVal;
  assign selIdx = takeB ? bIdx : aIdx;
endmodule

// File: rtl/mrc_ctrl.sv
module mrc_ctrl
  import mrc_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output mrc_strobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.capture = inValid && rstN;
    strobe.clear   = !rstN;
  end

  generate
    if (OUT_REG) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;

      AST_RESET_CLEARS: assert property (@(posedge clk)
        !rstN |=> !outValid);                                     // R1
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);                                    // R2
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);                                  // R2
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/mrc_datapath.sv
module mrc_datapath
  import mrc_pkg::*;
#(
  parameter int  NUM_STATES = 8,
  parameter int  METRIC_W   = 12,
  parameter int  RANGE_W    = 8,
  parameter bit  OUT_REG    = 1'b1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  mrc_strobe_t                         strobe,
  input  logic [NUM_STATES-1:0][METRIC_W-1:0] metrics,
  output logic [RANGE_W-1:0]                  outRange,
  output logic [$clog2(NUM_STATES)-1:0]       outMaxIdx,
  output logic [$clog2(NUM_STATES)-1:0]       outMinIdx
);
  localparam int IW        = $clog2(NUM_STATES);
  localparam int LEVELS    = IW;
  localparam int NODES     = NUM_STATES - 1;
  localparam int PAIRS     = NUM_STATES / 2;
  localparam int ROOT      = NODES - 1;
  localparam int SPREAD_W  = METRIC_W + 1;
  localparam logic [SPREAD_W-1:0] CLIP_LIM = SPREAD_W'((1 << RANGE_W) - 1);

  // Flat node arrays: level 0 = pair cells, higher levels = pick cells.
  logic [METRIC_W-1:0] hiV [NODES];
  logic [IW-1:0]       hiI [NODES];
  logic [METRIC_W-1:0] loV [NODES];
  logic [IW-1:0]       loI [NODES];

  generate
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      mrc_maxmin_cell #(.W(METRIC_W), .IW(IW)) u_pair (
        .aVal (metrics[2*p]),
        .aIdx (IW'(2*p)),
        .bVal (metrics[2*p+1]),
        .bIdx (IW'(2*p+1)),
        .hiVal(hiV[p]),
        .hiIdx(hiI[p]),
        .loVal(loV[p]),
        .loIdx(loI[p])
      );
    end

    for (genvar lv = 1; lv < LEVELS; lv++) begin : g_lvl
      localparam int BASE  = levelBase(NUM_STATES, lv);
      localparam int PBASE = levelBase(NUM_STATES, lv - 1);
      for (genvar n = 0; n < (NUM_STATES >> (lv + 1)); n++) begin : g_node
        mrc_pick_cell #(.W(METRIC_W), .IW(IW), .PICK_MAX(1'b1)) u_max (
          .aVal  (hiV[PBASE+2*n]),
          .aIdx  (hiI[PBASE+2*n]),
          .bVal  (hiV[PBASE+2*n+1]),
          .bIdx  (hiI[PBASE+2*n+1]),
          .selVal(hiV[BASE+n]),
          .selIdx(hiI[BASE+n])
        );
        mrc_pick_cell #(.W(METRIC_W), .IW(IW), .PICK_MAX(1'b0)) u_min (
          .aVal  (loV[PBASE+2*n]),
          .aIdx  (loI[PBASE+2*n]),
          .bVal  (loV[PBASE+2*n+1]),
          .bIdx  (loI[PBASE+2*n+1]),
          .selVal(loV[BASE+n]),
          .selIdx(loI[BASE+n])
        );
      end
    end
  endgenerate

  // Subtract and clip.
  logic [SPREAD_W-1:0] spread;
  logic [RANGE_W-1:0]  clipped;

  always_comb begin
    spread  = {hiV[ROOT][METRIC_W-1], hiV[ROOT]} - {loV[ROOT][METRIC_W-1], loV[ROOT]};
    clipped = (spread > CLIP_LIM) ? RANGE_W'(CLIP_LIM) : spread[RANGE_W-1:0];
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [RANGE_W-1:0] rangeQ;
      logic [IW-1:0]      maxQ;
      logic [IW-1:0]      minQ;

      always_ff @(posedge clk) begin
        if (strobe.clear) begin
          rangeQ <= '0;
          maxQ   <= '0;
          minQ   <= '0;
        end else if (strobe.capture) begin
          rangeQ <= clipped;
          maxQ   <= hiI[ROOT];
          minQ   <= loI[ROOT];
        end
      end

      assign outRange  = rangeQ;
      assign outMaxIdx = maxQ;
      assign outMinIdx = minQ;

      AST_RESET_ZERO: assert property (@(posedge clk)
        !rstN |=> (outRange == '0 && outMaxIdx == '0 && outMinIdx == '0)); // R1
      AST_CLIP_CEILING: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.capture && spread > CLIP_LIM) |=> outRange == RANGE_W'(CLIP_LIM)); // R4
      AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.capture |=> ($stable(outRange) && $stable(outMaxIdx) && $stable(outMinIdx))); // R7
      AST_MAX_INDEX_MATCH: assert property (@(posedge clk) disable iff (!rstN)
        strobe.capture |-> metrics[hiI[ROOT]] == hiV[ROOT]);     // R5
      AST_MIN_INDEX_MATCH: assert property (@(posedge clk) disable iff (!rstN)
        strobe.capture |-> metrics[loI[ROOT]] == loV[ROOT]);     // R6
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
        strobe.capture |-> !spread[SPREAD_W-1] || spread > CLIP_LIM); // R3
    end else begin : g_comb
      assign outRange  = clipped;
      assign outMaxIdx = hiI[ROOT];
      assign outMinIdx = loI[ROOT];
    end
  endgenerate
endmodule

// File: rtl/metric_range_compressor.sv
module metric_range_compressor
  import mrc_pkg::*;
#(
  parameter int NUM_STATES = 8,
  parameter int METRIC_W   = 12,
  parameter int RANGE_W    = 8,
  parameter bit OUT_REG    = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic [NUM_STATES-1:0][METRIC_W-1:0] in_metrics,
  output logic                                out_valid,
  output logic [RANGE_W-1:0]                  out_range,
  output logic [$clog2(NUM_STATES)-1:0]       out_max_idx,
  output logic [$clog2(NUM_STATES)-1:0]       out_min_idx
);
  mrc_strobe_t strobe;

  mrc_ctrl #(.OUT_REG(OUT_REG)) u_ctrl (
    .clk     (clk),
    .rstN    (rst_n),
    .inValid (in_valid),
    .strobe  (strobe),
    .outValid(out_valid)
  );

  mrc_datapath #(
    .NUM_STATES(NUM_STATES),
    .METRIC_W  (METRIC_W),
    .RANGE_W   (RANGE_W),
    .OUT_REG   (OUT_REG)
  ) u_dp (
    .clk      (clk),
    .rstN     (rst_n),
    .strobe   (strobe),
    .metrics  (in_metrics),
    .outRange (out_range),
    .outMaxIdx(out_max_idx),
    .outMinIdx(out_min_idx)
  );
endmodule

// File: tb/sim_metric_range_compressor.sv
module sim_metric_range_compressor;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int MW = 12;
  localparam int RW = 8;
  localparam int NV = 10;
  localparam int LIM = (1 << RW) - 1;

  // Stimulus table: state 7 first, state 0 last.
  localparam logic [NS*MW-1:0] VEC [NV] = '{
    {12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000},
    {12'h123, 12'h123, 12'h123, 12'h123, 12'h123, 12'h123, 12'h123, 12'h123},
    {12'h000, 12'h000, 12'h800, 12'h000, 12'h7FF, 12'h000, 12'h000, 12'h000},
    {12'h000, 12'h064, 12'h000, 12'hFCE, 12'h000, 12'h064, 12'hFCE, 12'h000},
    {12'h002, 12'hFFD, 12'h005, 12'h001, 12'h000, 12'hFFF, 12'h004, 12'h000},
    {12'h0C8, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'hFC9, 12'h000},
    {12'h0C8, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'hFC8, 12'h000},
    {12'hF00, 12'hF80, 12'hFFF, 12'hE00, 12'hFF0, 12'hF01, 12'hFFE, 12'h000},
    {12'h7FF, 12'h7FF, 12'h7FF, 12'h7FF, 12'h7FF, 12'h7FF, 12'h7FF, 12'h7FF},
    {12'h800, 12'h800, 12'h800, 12'h800, 12'h800, 12'h800, 12'h800, 12'h7FF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [NS-1:0][MW-1:0] in_metrics = '0;
  logic out_valid;
  logic [RW-1:0] out_range;
  logic [2:0] out_max_idx;
  logic [2:0] out_min_idx;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  metric_range_compressor u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_metrics(in_metrics),
    .out_valid(out_valid), .out_range(out_range),
    .out_max_idx(out_max_idx), .out_min_idx(out_min_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference: strict compares keep the lowest state number on ties.
  task automatic refModel(input logic [NS-1:0][MW-1:0] m,
                          output int rng, output int mx, output int mn, output bit clip);
    int hi = $signed(m[0]);
    int lo = $signed(m[0]);
    mx = 0;
    mn = 0;
    for (int s = 1; s < NS; s++) begin
      if (int'($signed(m[s])) > hi) begin hi = $signed(m[s]); mx = s; end
      if (int'($signed(m[s])) < lo) begin lo = $signed(m[s]); mn = s; end
    end
    clip = (hi - lo) > LIM;
    rng  = clip ? LIM : hi - lo;
  endtask

  task automatic runVec(input logic [NS-1:0][MW-1:0] m);
    int eR, eMx, eMn;
    bit clip;
    refModel(m, eR, eMx, eMn, clip);
    @(negedge clk);
    in_metrics = m;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_metrics = ~m;
    chk("R2 out_valid after strobe", int'(out_valid), 1);
    chk(clip ? "R4 clipped range" : "R3 range", int'(out_range), eR);
    chk("R5 max index", int'(out_max_idx), eMx);
    chk("R6 min index", int'(out_min_idx), eMn);
    @(negedge clk);
    chk("R2 out_valid idle", int'(out_valid), 0);
    chk("R7 range held", int'(out_range), eR);
    chk("R7 max index held", int'(out_max_idx), eMx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 range in reset", int'(out_range), 0);
    chk("R1 max index in reset", int'(out_max_idx), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) runVec(VEC[v]);

    // R8: all-equal sets give zero spread and index 0.
    runVec({NS{12'hA5A}});
    chk("R8 all equal range", int'(out_range), 0);
    chk("R8 all equal min index", int'(out_min_idx), 0);

    // Random sets, mostly narrow spreads with occasional wide ones.
    for (int r = 0; r < 60; r++) begin
      logic [NS-1:0][MW-1:0] m;
      int span = (r % 4 == 0) ? 4096 : 300;
      for (int s = 0; s < NS; s++)
        m[s] = MW'(int'($urandom_range(span - 1, 0)) - span / 2);
      m[0] = '0;
      runVec(m);
    end

    // R1: reset wins over a strobe in the same edge and zeroes the word.
    @(negedge clk);
    in_metrics = VEC[2];
    in_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset over strobe valid", int'(out_valid), 0);
    chk("R1 reset over strobe range", int'(out_range), 0);
    chk("R1 reset over strobe min index", int'(out_min_idx), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 no valid after reset", int'(out_valid), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule